// File: doc/BRIEF.md
# Serial Conversion Readout Port

This block is the host-facing serial port of a data converter. It works entirely in the converter's master-clock domain. The host's SCLK, CS and DIN lines are oversampled through synchronizers, and the port detects SCLK edges from those samples. When the converter core finishes a conversion, it hands over a 24-bit two's-complement word with a one-cycle strobe. The port then pulls its active-low data-ready line low.

The host starts a read by pulling CS low. At that moment the port freezes the pending word into its shift register and releases data-ready. SCLK idles low. The port launches each output bit after a rising edge, and the host samples it on the next falling edge. After the 24 word bits, the output carries the bits the port captured from the daisy-chain input, delayed by 24 SCLK cycles. This lets several converters be read as one long chain.

The first eight DIN bits form a command byte. The command is presented to the core after a fixed decode delay. An inactivity watchdog clears the shift state of a transfer that has stalled.

Top module: `spi_readout`

## Requirements
- R1: `dout_oe_o` is low whenever CS, taken through the two-stage synchronizer, is high. It is high while that synchronized CS is low, so it follows the pin with a two-clock delay.
- R2: `drdy_no` is high after reset. It falls one clock after `conv_valid_i` and stays low until a read begins.
- R3: `drdy_no` returns high in the cycle in which a CS falling edge starts a new transfer.
- R4: The latched word leaves on `dout_o` MSB first, one bit per SCLK cycle. The MSB is present from the start of the transfer. Each later bit appears after the SCLK rising edge that follows the host's falling-edge sample of the previous bit.
- R5: From the 25th SCLK cycle on, the value the host samples on falling edge 24+j is the daisy-chain input captured on falling edge j.
- R6: The word is latched when CS falls. A new conversion strobe during a transfer leaves that transfer's output unchanged, and the next transfer returns the new word.
- R7: CS high for fewer than 6 synchronized clocks is ignored. The bit position and the command progress are kept, and only `dout_oe_o` drops during the glitch.
- R8: CS high for at least 6 clocks ends the transfer. The next CS fall latches the most recent word.
- R9: The first 8 DIN bits, captured on SCLK falling edges MSB first, appear on `cmd_o`. At the same time `cmd_valid_o` pulses for one clock, 4 clocks after the clock edge that registers the 8th falling edge. That is 7 clocks after the pin edge.
- R10: If a transfer sees no SCLK edge and no CS change for 2^16 clocks (`tout_short_i`=0) or 2^14 clocks (`tout_short_i`=1), its shift state is cleared. `dout_o` then reads 0 until a new transfer starts.
- R11: DIN bits after the 8th are ignored, so exactly one command pulse is issued per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Host serial clock, idles low |
| cs_ni | input | 1 | Host chip select, active low |
| din_i | input | 1 | Host serial data in (command) |
| chain_i | input | 1 | Daisy-chain data from the next device |
| tout_short_i | input | 1 | 1 selects the 2^14-clock inactivity limit |
| conv_data_i | input | 24 | Conversion word from the core |
| conv_valid_i | input | 1 | One-cycle strobe: conv_data_i is new |
| drdy_no | output | 1 | Data ready, active low |
| dout_o | output | 1 | Serial data out |
| dout_oe_o | output | 1 | Pad enable for dout_o |
| cmd_o | output | 8 | Last decoded command byte |
| cmd_valid_o | output | 1 | One-cycle command strobe |

## Verification
The words read back have distinct shapes:
- a lone MSB and LSB (0x800001), which exposes a shift that is off by one at either end;
- alternating nibbles (0x5A3C96), which exposes reversed bit order;
- all ones and all zeros, each followed by an opposite chain pattern, which shows exactly where the word ends and the chain data begins.

A conversion strobe in the middle of a transfer shows whether the output word is latched or live. A short CS glitch, set against a full CS-high gap, tells filtering apart from a restart. Idle transfers held just below and just above both timeout limits show which limit `tout_short_i` selects.

// File: rtl/spi_ro_pkg.sv
`timescale 1ns/1ps
package spi_ro_pkg;
  localparam int unsigned WORD_W       = 24;
  localparam int unsigned CMD_W        = 8;
  localparam int unsigned SYNC_STAGES  = 2;
  localparam int unsigned CS_MIN_HIGH  = 6;
  localparam int unsigned DECODE_CLKS  = 4;
  localparam int unsigned TOUT_LONG_W  = 16;
  localparam int unsigned TOUT_SHORT_W = 14;

  // bit positions inside the synchronized pin vector
  typedef enum int unsigned {
    PIN_CHAIN = 0,
    PIN_DIN   = 1,
    PIN_CS    = 2,
    PIN_SCLK  = 3
  } pin_idx_e;
endpackage

// File: rtl/spi_ro_sync.sv
`timescale 1ns/1ps
module spi_ro_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_ro_shifter.sv
`timescale 1ns/1ps
module spi_ro_shifter #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         fall_i,
  input  logic         rise_i,
  input  logic         chain_i,
  output logic         msb_o
);
  logic [W-1:0] sh_q;
  logic         pend_q;   // a falling edge was seen since the last shift
  logic         chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      pend_q  <= 1'b0;
      chain_q <= 1'b0;
    end else if (clr_i) begin
      sh_q    <= '0;
      pend_q  <= 1'b0;
    end else if (load_i) begin
      sh_q    <= data_i;
      pend_q  <= 1'b0;
    end else if (fall_i) begin
      chain_q <= chain_i;
      pend_q  <= 1'b1;
    end else if (rise_i && pend_q) begin
      sh_q    <= {sh_q[W-2:0], chain_q};
      pend_q  <= 1'b0;
    end
  end

  assign msb_o = sh_q[W-1];
endmodule

// File: rtl/spi_ro_cmd.sv
`timescale 1ns/1ps
module spi_ro_cmd #(
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned DECODE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             fall_i,
  input  logic             din_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             cmd_valid_o
);
  localparam int unsigned CNT_W = $clog2(CMD_W + 1);
  localparam int unsigned DEC_W = $clog2(DECODE + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);
  localparam logic [DEC_W-1:0] DEC_LOAD = DEC_W'(DECODE);
  localparam logic [DEC_W-1:0] DEC_ONE  = DEC_W'(1);

  logic [CMD_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEC_W-1:0] dec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q        <= '0;
      cnt_q       <= '0;
      dec_q       <= '0;
      cmd_o       <= '0;
      cmd_valid_o <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (dec_q != '0) begin
        dec_q <= dec_q - DEC_ONE;
        if (dec_q == DEC_ONE) begin
          cmd_o       <= sh_q;
          cmd_valid_o <= 1'b1;
        end
      end
      if (clr_i) begin
        cnt_q <= '0;
        dec_q <= '0;
      end else if (fall_i && cnt_q != CNT_FULL) begin
        sh_q  <= {sh_q[CMD_W-2:0], din_i};
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_LAST) dec_q <= DEC_LOAD;
      end
    end
  end
endmodule

// File: rtl/spi_readout.sv
`timescale 1ns/1ps
module spi_readout
  import spi_ro_pkg::*;
#(
  parameter int unsigned DATA_W    = WORD_W,
  parameter int unsigned CMD_BITS  = CMD_W,
  parameter int unsigned SYNC_N    = SYNC_STAGES,
  parameter int unsigned CS_MIN    = CS_MIN_HIGH,
  parameter int unsigned DECODE    = DECODE_CLKS,
  parameter int unsigned TOUT_LW   = TOUT_LONG_W,
  parameter int unsigned TOUT_SW   = TOUT_SHORT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                cs_ni,
  input  logic                din_i,
  input  logic                chain_i,
  input  logic                tout_short_i,
  input  logic [DATA_W-1:0]   conv_data_i,
  input  logic                conv_valid_i,
  output logic                drdy_no,
  output logic                dout_o,
  output logic                dout_oe_o,
  output logic [CMD_BITS-1:0] cmd_o,
  output logic                cmd_valid_o
);
  localparam int unsigned CSC_W = $clog2(CS_MIN + 1);
  localparam logic [CSC_W-1:0] CS_END = CSC_W'(CS_MIN - 1);
  localparam logic [TOUT_LW-1:0] LIM_LONG  = {TOUT_LW{1'b1}};
  localparam logic [TOUT_LW-1:0] LIM_SHORT = TOUT_LW'((1 << TOUT_SW) - 1);

  logic [3:0] pins_s;
  logic sclk_s, cs_s, din_s, chain_s;
  logic sclk_q, cs_q;
  logic sclk_rise, sclk_fall, cs_fall, activity;
  logic active_q, start, end_xfer, tout_hit, clr;
  logic [CSC_W-1:0]   cs_hi_q;
  logic [TOUT_LW-1:0] idle_q, idle_lim;
  logic [DATA_W-1:0]  word_q;

  spi_ro_sync #(.W(4), .STAGES(SYNC_N), .RST_VAL(4'b0100)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, din_i, chain_i}),
    .q_o   (pins_s)
  );

  assign sclk_s  = pins_s[PIN_SCLK];
  assign cs_s    = pins_s[PIN_CS];
  assign din_s   = pins_s[PIN_DIN];
  assign chain_s = pins_s[PIN_CHAIN];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
    end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign cs_fall   = cs_q & ~cs_s;
  assign activity  = sclk_rise | sclk_fall | (cs_s ^ cs_q);

  // transfer framing: CS must stay high CS_MIN clocks to end a transfer
  assign start    = cs_fall & ~active_q;
  assign end_xfer = active_q & cs_s & (cs_hi_q == CS_END);
  assign idle_lim = tout_short_i ? LIM_SHORT : LIM_LONG;
  assign tout_hit = active_q & ~activity & (idle_q == idle_lim);
  assign clr      = end_xfer | tout_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cs_hi_q  <= '0;
      idle_q   <= '0;
    end else begin
      if (start)    active_q <= 1'b1;
      else if (clr) active_q <= 1'b0;

      if (!active_q || !cs_s || clr) cs_hi_q <= '0;
      else                           cs_hi_q <= cs_hi_q + CSC_W'(1);

      if (!active_q || activity || clr) idle_q <= '0;
      else                              idle_q <= idle_q + TOUT_LW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      drdy_no <= 1'b1;
    end else begin
      if (conv_valid_i) begin
        word_q  <= conv_data_i;
        drdy_no <= 1'b0;
      end else if (start) begin
        drdy_no <= 1'b1;
      end
    end
  end

  spi_ro_shifter #(.W(DATA_W)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .load_i (start),
    .data_i (word_q),
    .fall_i (sclk_fall & active_q),
    .rise_i (sclk_rise & active_q),
    .chain_i(chain_s),
    .msb_o  (dout_o)
  );

  spi_ro_cmd #(.CMD_W(CMD_BITS), .DECODE(DECODE)) i_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start | clr),
    .fall_i     (sclk_fall & active_q),
    .din_i      (din_s),
    .cmd_o      (cmd_o),
    .cmd_valid_o(cmd_valid_o)
  );

  assign dout_oe_o = ~cs_s;
endmodule

// File: rtl/spi_readout_chk.sv
`timescale 1ns/1ps
module spi_readout_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic conv_valid_i,
  input logic drdy_no,
  input logic dout_oe_o,
  input logic cmd_valid_o
);
  a_r1_oe_off_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni, 2) |-> !dout_oe_o);

  a_r2_drdy_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_valid_i |=> !drdy_no);

  a_r3_drdy_rise_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drdy_no) |-> dout_oe_o);

  a_r9_cmd_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
endmodule

bind spi_readout spi_readout_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .conv_valid_i(conv_valid_i),
  .drdy_no     (drdy_no),
  .dout_oe_o   (dout_oe_o),
  .cmd_valid_o (cmd_valid_o)
);

// File: tb/test_spi_readout.sv
`timescale 1ns/1ps
module test_spi_readout;
  localparam int CLK_NS = 20;
  localparam int HALF   = 8;
  localparam int LAT_CMD = (2 + 1 + 4) * CLK_NS;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        sclk_i = 1'b0, cs_ni = 1'b1, din_i = 1'b0, chain_i = 1'b0;
  logic        tout_short_i = 1'b0;
  logic [23:0] conv_data_i = '0;
  logic        conv_valid_i = 1'b0;
  logic        drdy_no, dout_o, dout_oe_o, cmd_valid_o;
  logic [7:0]  cmd_o;

  int checks = 0, failures = 0, ncmd = 0;
  longint t8 = 0, t_cmd = 0;
  logic exp_q[$];

  always #(CLK_NS/2) clk_i = ~clk_i;

  spi_readout i_spi_readout (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .cs_ni(cs_ni),
    .din_i(din_i), .chain_i(chain_i), .tout_short_i(tout_short_i),
    .conv_data_i(conv_data_i), .conv_valid_i(conv_valid_i),
    .drdy_no(drdy_no), .dout_o(dout_o), .dout_oe_o(dout_oe_o),
    .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o)
  );

  always @(negedge clk_i)
    if (cmd_valid_o) begin
      ncmd++;
      t_cmd = $time;
    end

  task automatic clks(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic push_word(logic [23:0] w);
    conv_data_i  = w;
    conv_valid_i = 1'b1;
    clks(1);
    conv_valid_i = 1'b0;
    chk("R2 drdy low after strobe", drdy_no, 0);
  endtask

  // driver fills the scoreboard; the per-bit sampler pops and compares
  task automatic xfer(int nbits, logic [7:0] cmd, logic [31:0] chain,
                      logic [23:0] word, bit mid_en, logic [23:0] mid_word,
                      int glitch_at);
    for (int k = 1; k <= nbits; k++)
      exp_q.push_back(k <= 24 ? word[24-k] : chain[k-25]);
    ncmd = 0;
    cs_ni = 1'b0;
    clks(4);
    chk("R3 drdy high at read start", drdy_no, 1);
    chk("R1 oe on with CS low", dout_oe_o, 1);
    for (int k = 0; k < nbits; k++) begin
      sclk_i  = 1'b1;
      din_i   = (k < 8) ? cmd[7-k] : 1'b1;
      chain_i = chain[k];
      clks(HALF);
      chk(k < 24 ? "R4 word bit" : "R5 chain bit", dout_o, exp_q.pop_front());
      sclk_i = 1'b0;
      if (k == 7) t8 = $time;
      clks(HALF);
      if (mid_en && k == 11) push_word(mid_word);
      if (glitch_at == k) begin
        cs_ni = 1'b1;
        clks(3);
        chk("R7 oe off during glitch", dout_oe_o, 0);
        clks(1);
        cs_ni = 1'b0;
        clks(4);
      end
    end
    clks(4);
    cs_ni = 1'b1;
    if (nbits >= 8) begin
      chk("R9 command value", cmd_o, cmd);
      chk("R9 command latency", 32'(t_cmd - t8), LAT_CMD);
      chk("R11 one command per transfer", ncmd, 1);
    end
    clks(10);
    chk("R1 oe off with CS high", dout_oe_o, 0);
  endtask

  task automatic idle_xfer(bit short_lim, int lim);
    tout_short_i = short_lim;
    push_word(24'h800000);
    cs_ni = 1'b0;
    clks(lim - 20);
    chk("R10 no clear before limit", dout_o, 1);
    clks(60);
    chk("R10 cleared after limit", dout_o, 0);
    cs_ni = 1'b1;
    clks(10);
  endtask

  initial begin
    clks(5);
    chk("R1 oe off in reset", dout_oe_o, 0);
    chk("R2 drdy high in reset", drdy_no, 1);
    rst_ni = 1'b1;
    clks(3);
    chk("R2 drdy idle high", drdy_no, 1);
    chk("R9 no command at idle", cmd_valid_o, 0);

    push_word(24'h800001);
    xfer(32, 8'hA7, 32'h0000_00C5, 24'h800001, 1'b0, '0, -1);

    push_word(24'h5A3C96);
    xfer(24, 8'h3C, 32'h0, 24'h5A3C96, 1'b1, 24'h123456, -1);
    chk("R6 new word pending after read", drdy_no, 0);
    xfer(28, 8'h01, 32'h0000_0005, 24'h123456, 1'b0, '0, -1); // R8 next fall latches newest

    push_word(24'hFFFFFF);
    xfer(30, 8'h80, 32'h0000_0000, 24'hFFFFFF, 1'b0, '0, 10);
    push_word(24'h000000);
    xfer(32, 8'hFE, 32'h0000_00FF, 24'h000000, 1'b0, '0, 3);

    idle_xfer(1'b1, 1 << 14);
    idle_xfer(1'b0, 1 << 16);
    push_word(24'hA5A5A5);
    xfer(24, 8'h55, 32'h0, 24'hA5A5A5, 1'b0, '0, -1); // R10 recovery

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(3_000_000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule